// File: doc/BRIEF.md
# Program-Sequenced NoC Output Arbiter

This block drives one output link of a five-port mesh router. It picks whole packets from the North, South, East, West and Local inputs and passes them one flit per cycle into a single registered output stage. It works in one of two modes. In scheduled mode, a small program memory lists the order of source ports. The arbiter waits for the listed input to offer a packet and forwards that packet. It then moves to the next entry, and it wraps to entry 0 after any entry marked as the end of the schedule. There is no time slot and no global clock reference: the arrival of the data paces the schedule. In round-robin mode, the arbiter serves the valid inputs in rotation.

A packet is a run of flits that ends with a flit carrying the tail sideband bit. Once the first flit of a packet has been taken, no other input is served until its tail has gone. Every input and the output use a valid/ready handshake. The output asserts backpressure and never drops a flit. The schedule is loaded through a simple write port while the arbiter is switched off. Switching it on restarts the schedule from entry 0.

Top module: `noc_out_arbiter`

## Requirements
- R1: While reset is high, and at the first cycle after it, out_vld is 0. All in_rdy bits are 0 until the arbiter is enabled.
- R2: With sched_mode=1, packets leave in the order given by the program entries. An entry's 3-bit port code k (0=North, 1=South, 2=East, 3=West, 4=Local) selects input bit k of in_vld/in_flit/in_last/in_rdy.
- R3: An entry whose wrap flag is 1 sends the schedule back to entry 0 after its packet, so the sequence repeats indefinitely.
- R4: In scheduled mode, a packet offered on an input other than the one the current entry names is not taken, even when the output is empty.
- R5: After a non-tail flit is taken from an input, the next flit taken comes from that same input, whatever the mode. A packet is never interleaved with another.
- R6: With sched_mode=0, the input granted is the first valid one at or after a rotating pointer, in increasing index order with wrap from 4 to 0. After a tail flit is taken, the pointer moves to the granted index plus one (mod 5). The pointer is 0 after reset.
- R7: While out_vld=1 and out_rdy=0, out_vld stays 1 and out_flit/out_last stay unchanged. No flit is lost or duplicated under any out_rdy pattern.
- R8: Program writes (pgm_we) made while arb_en=1 have no effect on the schedule.
- R9: While arb_en=0, no flit is taken. Each enable restarts the schedule at entry 0.
- R10: At most one in_rdy bit is high in a cycle, and only on an input whose in_vld is high. A flit taken at a clock edge is on out_flit/out_vld right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | Arbiter enable; program writes only land while low |
| sched_mode | input | 1 | 1 = follow program, 0 = round robin |
| pgm_we | input | 1 | Program entry write strobe |
| pgm_addr | input | $clog2(PGM_DEPTH) | Program entry index |
| pgm_port | input | 3 | Source port code for the entry |
| pgm_wrap | input | 1 | Entry ends the schedule; wrap to entry 0 |
| in_vld | input | 5 | Per-input flit valid |
| in_flit | input | 5*FLIT_W | Per-input flit data, input k at bits [k*FLIT_W +: FLIT_W] |
| in_last | input | 5 | Per-input tail-flit marker |
| in_rdy | output | 5 | Per-input flit accepted this cycle |
| out_vld | output | 1 | Output flit valid (registered) |
| out_flit | output | FLIT_W | Output flit data (registered) |
| out_last | output | 1 | Output tail marker (registered) |
| out_rdy | input | 1 | Downstream accepts the output flit |

## Verification
The scheduled order is driven with a five-entry program and packets of one to four flits. All sources are loaded at once, so a wrong entry decode or a missed wrap shows up as a packet from the wrong port at the output. A test with only a non-scheduled input loaded separates holding from work-conserving behaviour. A disable/enable test with a half-advanced schedule shows whether the program counter restarts. Round robin is tried with every input valid, which checks rotation and no interleaving of multi-flit packets. It is also tried with sparse pairs chosen so the result differs depending on whether the pointer follows the last granted index. A pseudo-random out_rdy pattern runs through the scheduled tests to exercise backpressure.

// File: rtl/noc_arb_pkg.sv
package noc_arb_pkg;
  localparam int NPORT = 5;
  localparam int SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    P_NORTH = 3'd0,
    P_SOUTH = 3'd1,
    P_EAST  = 3'd2,
    P_WEST  = 3'd3,
    P_LOCAL = 3'd4
  } port_e;

  typedef struct packed {
    logic  wrap;
    port_e src;
  } pgm_ent_t;
endpackage

// File: rtl/noc_pgm_mem.sv
module noc_pgm_mem
  import noc_arb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pgm_ent_t      wdata,
  input  logic [AW-1:0] raddr,
  output pgm_ent_t      rdata
);
  pgm_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/noc_rr_pick.sv
module noc_rr_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          any
);
  int j;
  always_comb begin
    idx = '0;
    any = 1'b0;
    j   = 0;
    // scan from farthest to nearest so the nearest requester wins last
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(ptr) + k) % N;
      if (req[j]) begin
        idx = IW'(j);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/noc_out_reg.sv
module noc_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         d_last,
  output logic         can_load,
  output logic         out_vld,
  output logic [W-1:0] out_flit,
  output logic         out_last,
  input  logic         out_rdy
);
  assign can_load = !out_vld || out_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
    end else if (can_load) begin
      out_vld <= load;
    end
    if (load) begin
      out_flit <= d;
      out_last <= d_last;
    end
  end
endmodule

// File: rtl/noc_out_arbiter.sv
module noc_out_arbiter
  import noc_arb_pkg::*;
#(
  parameter int FLIT_W    = 32,
  parameter int PGM_DEPTH = 16,
  localparam int AW = $clog2(PGM_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    arb_en,
  input  logic                    sched_mode,
  input  logic                    pgm_we,
  input  logic [AW-1:0]           pgm_addr,
  input  logic [SRC_W-1:0]        pgm_port,
  input  logic                    pgm_wrap,
  input  logic [NPORT-1:0]        in_vld,
  input  logic [NPORT*FLIT_W-1:0] in_flit,
  input  logic [NPORT-1:0]        in_last,
  output logic [NPORT-1:0]        in_rdy,
  output logic                    out_vld,
  output logic [FLIT_W-1:0]       out_flit,
  output logic                    out_last,
  input  logic                    out_rdy
);
  localparam int NSEL = 1 << SRC_W;

  // inputs padded to every code a 3-bit field can hold
  logic [FLIT_W-1:0] din  [NSEL];
  logic [NSEL-1:0]   vpad, lpad;

  for (genvar g = 0; g < NSEL; g++) begin : g_pad
    if (g < NPORT) begin : g_real
      assign din[g]  = in_flit[g*FLIT_W +: FLIT_W];
      assign vpad[g] = in_vld[g];
      assign lpad[g] = in_last[g];
    end else begin : g_none
      assign din[g]  = '0;
      assign vpad[g] = 1'b0;
      assign lpad[g] = 1'b0;
    end
  end

  logic             locked;
  logic [SRC_W-1:0] cur_src, rr_ptr, rr_idx, cand_src, sel;
  logic             rr_any, cand_ok, sel_ok, move, can_load;
  logic [AW-1:0]    pc;
  pgm_ent_t         ent;

  noc_pgm_mem #(.DEPTH(PGM_DEPTH)) u_pgm (
    .clk   (clk),
    .we    (pgm_we && !arb_en),
    .waddr (pgm_addr),
    .wdata ({pgm_wrap, port_e'(pgm_port)}),
    .raddr (pc),
    .rdata (ent)
  );

  noc_rr_pick #(.N(NPORT), .IW(SRC_W)) u_rr (
    .req (in_vld),
    .ptr (rr_ptr),
    .idx (rr_idx),
    .any (rr_any)
  );

  always_comb begin
    if (sched_mode) begin
      cand_src = ent.src;
      cand_ok  = vpad[ent.src];
    end else begin
      cand_src = rr_idx;
      cand_ok  = rr_any;
    end
    sel    = locked ? cur_src : cand_src;
    sel_ok = locked ? vpad[cur_src] : cand_ok;
    move   = arb_en && sel_ok && can_load;
    in_rdy = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (move && (sel == SRC_W'(p))) in_rdy[p] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      cur_src <= '0;
      pc      <= '0;
      rr_ptr  <= '0;
    end else begin
      if (!arb_en) pc <= '0;
      if (move) begin
        if (lpad[sel]) begin
          locked <= 1'b0;
          if (sched_mode) pc <= ent.wrap ? '0 : pc + AW'(1);
          else rr_ptr <= (sel == SRC_W'(NPORT - 1)) ? '0 : sel + SRC_W'(1);
        end else begin
          locked  <= 1'b1;
          cur_src <= sel;
        end
      end
    end
  end

  noc_out_reg #(.W(FLIT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (move),
    .d        (din[sel]),
    .d_last   (lpad[sel]),
    .can_load (can_load),
    .out_vld  (out_vld),
    .out_flit (out_flit),
    .out_last (out_last),
    .out_rdy  (out_rdy)
  );
endmodule

// File: rtl/noc_out_arbiter_chk.sv
module noc_out_arbiter_chk
  import noc_arb_pkg::*;
#(
  parameter int FLIT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              arb_en,
  input logic [NPORT-1:0]  in_vld,
  input logic [NPORT-1:0]  in_last,
  input logic [NPORT-1:0]  in_rdy,
  input logic              out_vld,
  input logic [FLIT_W-1:0] out_flit,
  input logic              out_last,
  input logic              out_rdy
);
  a_r1_reset_idle: assert property (@(posedge clk) $past(rst) |-> !out_vld);

  a_r10_one_ready: assert property (@(posedge clk) disable iff (rst) $onehot0(in_rdy));

  a_r10_ready_has_valid: assert property (@(posedge clk) disable iff (rst)
    (in_rdy & ~in_vld) == '0);

  a_r10_next_out: assert property (@(posedge clk) disable iff (rst)
    (in_rdy != '0) |=> out_vld);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_flit) && $stable(out_last)));

  a_r9_off_no_take: assert property (@(posedge clk) disable iff (rst)
    !arb_en |-> (in_rdy == '0));

  a_r5_no_switch: assert property (@(posedge clk) disable iff (rst)
    ((in_rdy & ~in_last) != '0) |=> ((in_rdy & ~$past(in_rdy)) == '0));
endmodule

bind noc_out_arbiter noc_out_arbiter_chk #(.FLIT_W(FLIT_W)) u_chk (.*);

// File: tb/tb_noc_out_arbiter.sv
`timescale 1ns/1ps
module tb_noc_out_arbiter;
  localparam int NP = 5;
  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0, rst = 1'b1, arb_en = 1'b0, sched_mode = 1'b0;
  logic          pgm_we = 1'b0, pgm_wrap = 1'b0;
  logic [AW-1:0] pgm_addr = '0;
  logic [2:0]    pgm_port = '0;
  logic [NP-1:0] in_vld = '0, in_last = '0, in_rdy;
  logic [NP*W-1:0] in_flit = '0;
  logic          out_vld, out_last, out_rdy = 1'b1;
  logic [W-1:0]  out_flit;

  always #2 clk = ~clk;

  noc_out_arbiter #(.FLIT_W(W), .PGM_DEPTH(16)) dut (.*);

  int nchk = 0, nbad = 0, tag_ctr = 1;
  logic [W:0]    smem [NP][256];
  int            wp [NP], rp [NP];
  logic [NP-1:0] popv = '0;
  logic [W:0]    exp_q [$];
  string         exp_r [$];
  logic          bp_on = 1'b0, hold = 1'b0;
  logic [W:0]    hold_v = '0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic check(input string r, input logic ok, input logic [W:0] act, input logic [W:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  function automatic logic [W-1:0] mk(input int tg, input int p, input int i);
    return {tg[7:0], p[3:0], i[3:0]};
  endfunction

  task automatic add_src(input int p, input int len, output int tg);
    tg = tag_ctr;
    tag_ctr++;
    for (int i = 0; i < len; i++) begin
      smem[p][wp[p] % 256] = {(i == len - 1), mk(tg, p, i)};
      wp[p]++;
    end
  endtask

  task automatic add_exp(input int p, input int len, input int tg, input string r);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({(i == len - 1), mk(tg, p, i)});
      exp_r.push_back(r);
    end
  endtask

  task automatic pkt(input int p, input int len, input string r);
    int tg;
    add_src(p, len, tg);
    add_exp(p, len, tg, r);
  endtask

  // driver + monitor: drive at negedge, sample 1 ns later
  initial begin
    for (int p = 0; p < NP; p++) begin wp[p] = 0; rp[p] = 0; end
    forever begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) if (popv[p]) rp[p]++;
      for (int p = 0; p < NP; p++) begin
        in_vld[p]          = (rp[p] != wp[p]);
        in_last[p]         = smem[p][rp[p] % 256][W];
        in_flit[p*W +: W]  = smem[p][rp[p] % 256][W-1:0];
      end
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_rdy = bp_on ? lfsr[0] : 1'b1;
      #1;
      popv = in_vld & in_rdy;
      if (hold)
        check("R7 held flit", out_vld && ({out_last, out_flit} == hold_v), {out_last, out_flit}, hold_v);
      hold   = out_vld && !out_rdy;
      hold_v = {out_last, out_flit};
      if (out_vld && out_rdy) begin
        if (exp_q.size() == 0) begin
          check("R7 extra flit", 1'b0, {out_last, out_flit}, '0);
        end else begin
          logic [W:0] e;
          string r;
          e = exp_q.pop_front();
          r = exp_r.pop_front();
          check(r, {out_last, out_flit} == e, {out_last, out_flit}, e);
        end
      end
    end
  end

  task automatic wr_pgm(input int a, input int src, input logic wr);
    @(negedge clk);
    pgm_we = 1'b1; pgm_addr = AW'(a); pgm_port = 3'(src); pgm_wrap = wr;
    @(negedge clk);
    pgm_we = 1'b0;
  endtask

  task automatic drain(input string r);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    nchk++;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL %s drain actual=%0d_left expected=0_left", r, exp_q.size());
      exp_q.delete(); exp_r.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input string r);
    @(negedge clk); #1;
    check(r, !out_vld && (in_rdy == '0), {out_vld, 11'd0, in_rdy}, '0);
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nbad++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #1;
    check("R1 reset out_vld", !out_vld, {16'd0, out_vld}, '0);
    @(negedge clk);
    rst = 1'b0;
    idle_check("R1 idle after reset");

    // R4: only a non-scheduled input is loaded
    wr_pgm(0, 1, 1'b0);
    wr_pgm(1, 0, 1'b1);
    sched_mode = 1'b1;
    arb_en = 1'b1;
    begin
      int t0, t1;
      add_src(0, 2, t0);
      repeat (20) @(negedge clk);
      idle_check("R4 hold unscheduled");
      add_src(1, 3, t1);
      add_exp(1, 3, t1, "R4 scheduled first");
      add_exp(0, 2, t0, "R4 held packet after");
    end
    drain("R4");

    // R2/R3: five-entry schedule, two rounds, backpressure on
    @(negedge clk); arb_en = 1'b0;
    wr_pgm(0, 2, 1'b0); wr_pgm(1, 0, 1'b0); wr_pgm(2, 4, 1'b0);
    wr_pgm(3, 1, 1'b0); wr_pgm(4, 3, 1'b1);
    bp_on = 1'b1;
    arb_en = 1'b1;
    pkt(2, 3, "R2 order e0"); pkt(0, 1, "R2 order e1"); pkt(4, 2, "R2 order e2");
    pkt(1, 4, "R2 order e3"); pkt(3, 2, "R2 order e4");
    pkt(2, 1, "R3 wrap e0"); pkt(0, 4, "R3 wrap e1"); pkt(4, 1, "R3 wrap e2");
    pkt(1, 2, "R3 wrap e3"); pkt(3, 3, "R3 wrap e4");
    drain("R3");

    // R8: write while enabled must be ignored
    wr_pgm(0, 4, 1'b1);
    pkt(2, 2, "R8 ignored write"); pkt(0, 2, "R8 ignored write");
    pkt(4, 1, "R8 ignored write"); pkt(1, 1, "R8 ignored write");
    pkt(3, 2, "R8 ignored write");
    drain("R8");
    bp_on = 1'b0;

    // R9: disabled takes nothing; enable restarts at entry 0
    @(negedge clk); arb_en = 1'b0;
    wr_pgm(0, 0, 1'b0); wr_pgm(1, 1, 1'b0); wr_pgm(2, 2, 1'b1);
    arb_en = 1'b1;
    pkt(0, 2, "R9 first pass");
    drain("R9");
    @(negedge clk); arb_en = 1'b0;
    begin
      int ta, tb;
      add_src(0, 2, ta);
      repeat (10) @(negedge clk);
      idle_check("R9 disabled no take");
      add_src(1, 1, tb);
      add_exp(0, 2, ta, "R9 restart at entry0");
      add_exp(1, 1, tb, "R9 restart entry1");
    end
    @(negedge clk); arb_en = 1'b1;
    drain("R9");

    // R6/R5: round robin from a fresh pointer
    @(negedge clk); arb_en = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0; sched_mode = 1'b0;
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < NP; p++) pkt(p, (p % 3) + 2, "R6 R5 rotation");
    @(negedge clk); arb_en = 1'b1;
    drain("R6");
    @(negedge clk); arb_en = 1'b0;
    pkt(1, 2, "R6 ptr0 picks 1"); pkt(3, 1, "R6 then 3");
    @(negedge clk); arb_en = 1'b1;
    drain("R6");
    @(negedge clk); arb_en = 1'b0;
    pkt(0, 1, "R6 ptr4 wraps to 0"); pkt(3, 2, "R6 then 3");
    @(negedge clk); arb_en = 1'b1;
    drain("R6");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule